// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This block sits beside the privileged-instruction path of a core that runs guest code under a hypervisor. For each decoded privileged access it decides whether the access must trap to the hypervisor or may execute directly. The decision depends on four inputs: the access class, the set/reset mask of status-bit instructions, the guest-mode flag from the processor status word, and a per-virtual-processor vector of bypass controls. Each bypass control lets one class of resource be touched directly by the guest.

The decision is captured on a valid strobe and is presented one clock later, together with a one-cycle result-valid pulse. A separate combinational flag reports a forbidden combination of the interrupt-bit bypass and certain accelerations. Software samples this flag when a virtual processor is created or registered.

Top module: `virt_trap_decider`

## Requirements
- R1: After synchronous reset, `trap_out` and `trap_vld` are 0.
- R2: When `guest_mode` is 0, no access class produces an intercept.
- R3: With `guest_mode` 1, classes 1 (monitor configuration read) and 2 (monitor configuration write) intercept unless `dis_ctrl[0]` is 1.
- R4: With `guest_mode` 1, class 3 (monitor data write) intercepts unless `dis_ctrl[1]` is 1. Class 4 (monitor data read) never intercepts.
- R5: With `guest_mode` 1, class 5 (timer match write) intercepts unless `dis_ctrl[2]` is 1.
- R6: With `guest_mode` 1, a class 6 (set/reset mask) access whose mask has only bit `INT_BIT` (default 14) set passes when `dis_ctrl[3]` is 1 and intercepts when it is 0.
- R7: With `guest_mode` 1, a class 6 access whose mask has any bit other than `INT_BIT` set intercepts whatever the controls are. An all-zero mask never intercepts.
- R8: With `guest_mode` 1, class 7 (whole status-word move) always intercepts, even when `dis_ctrl[3]` is 1.
- R9: Class 0 (no privileged access) never intercepts.
- R10: The decision for an access presented with `acc_valid` 1 appears on `trap_out` one clock later, with `trap_vld` 1 for that cycle. Cycles without `acc_valid` drive `trap_vld` to 0 and leave `trap_out` unchanged.
- R11: `cfg_err` is 1 exactly when `dis_ctrl[3]` is 1 and at least one `accel_en` bit is set. The `accel_en` bits are: bit 0 interrupt acceleration, bit 1 status-read acceleration, bit 2 bank-switch acceleration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access descriptor strobe |
| acc_class | input | 3 | Access class code 0..7 |
| acc_mask | input | MASK_W | Set/reset mask for class 6 |
| guest_mode | input | 1 | Guest-mode flag from the status word |
| dis_ctrl | input | 4 | Bypass controls: 0 mon-cfg, 1 mon-data write, 2 timer, 3 interrupt bit |
| accel_en | input | 3 | Acceleration enables: 0 interrupt, 1 status read, 2 bank switch |
| trap_vld | output | 1 | Registered result-valid pulse |
| trap_out | output | 1 | Registered intercept decision |
| cfg_err | output | 1 | Combinational forbidden-configuration flag |

## Verification
Random descriptors cover every class with guest mode on and off and with all sixteen control settings. This separates a wrong class-to-bypass mapping from a missing guest-mode gate. Directed set/reset masks probe the interrupt-bit path with exactly that bit set, that bit plus a neighbour, and the zero mask, and a whole-word move is tried with every bypass set. Idle cycles with changing inputs confirm that the registered result holds. Sweeps of the accelerations against the interrupt-bit bypass confirm the error flag.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    localparam int CLS_W = 3;
    localparam int DIS_W = 4;
    localparam int ACC_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE      = 3'd0,
        CLS_MCFG_RD   = 3'd1,
        CLS_MCFG_WR   = 3'd2,
        CLS_MDAT_WR   = 3'd3,
        CLS_MDAT_RD   = 3'd4,
        CLS_TMATCH_WR = 3'd5,
        CLS_SRMASK    = 3'd6,
        CLS_SWMOVE    = 3'd7
    } acc_cls_e;

    typedef struct packed {
        logic ibit_bypass;
        logic tmr_bypass;
        logic mdat_bypass;
        logic mcfg_bypass;
    } dis_ctrl_t;

    typedef struct packed {
        logic bank_sw;
        logic stat_rd;
        logic intr;
    } accel_t;

    typedef struct packed {
        logic zero;
        logic int_only;
    } mask_info_t;

    function automatic logic class_decide(acc_cls_e cls, mask_info_t mi, dis_ctrl_t d);
        logic t;
        case (cls)
            CLS_MCFG_RD,
            CLS_MCFG_WR:   t = ~d.mcfg_bypass;
            CLS_MDAT_WR:   t = ~d.mdat_bypass;
            CLS_TMATCH_WR: t = ~d.tmr_bypass;
            CLS_SRMASK:    t = mi.zero ? 1'b0 : ~(mi.int_only & d.ibit_bypass);
            CLS_SWMOVE:    t = 1'b1;
            default:       t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/vtd_mask_probe.sv
module vtd_mask_probe
    import vtd_pkg::*;
#(
    parameter int MASK_W  = 24,
    parameter int INT_BIT = 14
) (
    input  logic [MASK_W-1:0] mask,
    output mask_info_t        info
);
    localparam logic [MASK_W-1:0] INT_MASK = {{(MASK_W-1){1'b0}}, 1'b1} << INT_BIT;

    logic [MASK_W-1:0] others;

    generate
        for (genvar i = 0; i < MASK_W; i++) begin : g_oth
            if (i == INT_BIT) begin : g_skip
                assign others[i] = 1'b0;
            end else begin : g_keep
                assign others[i] = mask[i];
            end
        end
    endgenerate

    assign info.zero     = (mask == '0);
    assign info.int_only = |(mask & INT_MASK) & ~(|others);
endmodule

// File: rtl/vtd_class_filter.sv
module vtd_class_filter
    import vtd_pkg::*;
(
    input  acc_cls_e   cls,
    input  mask_info_t minfo,
    input  logic       guest,
    input  dis_ctrl_t  dis,
    output logic       need_trap
);
    always_comb begin
        need_trap = guest ? class_decide(cls, minfo, dis) : 1'b0;
    end
endmodule

// File: rtl/vtd_cfg_check.sv
module vtd_cfg_check
    import vtd_pkg::*;
(
    input  dis_ctrl_t dis,
    input  accel_t    acc,
    output logic      err
);
    always_comb begin
        err = dis.ibit_bypass & (acc.intr | acc.stat_rd | acc.bank_sw);
    end
endmodule

// File: rtl/virt_trap_decider.sv
module virt_trap_decider
    import vtd_pkg::*;
#(
    parameter int MASK_W  = 24,
    parameter int INT_BIT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [2:0]        acc_class,
    input  logic [MASK_W-1:0] acc_mask,
    input  logic              guest_mode,
    input  logic [3:0]        dis_ctrl,
    input  logic [2:0]        accel_en,
    output logic              trap_vld,
    output logic              trap_out,
    output logic              cfg_err
);
    acc_cls_e   cls_s;
    dis_ctrl_t  dis_s;
    accel_t     acc_s;
    mask_info_t minfo;
    logic       need_trap;

    assign cls_s = acc_cls_e'(acc_class);
    assign dis_s = dis_ctrl;
    assign acc_s = accel_en;

    vtd_mask_probe #(.MASK_W(MASK_W), .INT_BIT(INT_BIT)) u_probe (
        .mask (acc_mask),
        .info (minfo)
    );

    vtd_class_filter u_filter (
        .cls       (cls_s),
        .minfo     (minfo),
        .guest     (guest_mode),
        .dis       (dis_s),
        .need_trap (need_trap)
    );

    vtd_cfg_check u_cfg (
        .dis (dis_s),
        .acc (acc_s),
        .err (cfg_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_vld <= 1'b0;
            trap_out <= 1'b0;
        end else begin
            trap_vld <= acc_valid;
            if (acc_valid) begin
                trap_out <= need_trap;
            end
        end
    end

    AST_HOST_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !guest_mode |=> !trap_out); // R2
    AST_MDAT_RD_PASS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_class == 3'd4 |=> !trap_out); // R4
    AST_SWMOVE_TRAP: assert property (@(posedge clk) disable iff (rst)
        acc_valid && guest_mode && acc_class == 3'd7 |=> trap_out); // R8
    AST_NONE_PASS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_class == 3'd0 |=> !trap_out); // R9
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> trap_vld); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !trap_vld && $stable(trap_out)); // R10
    AST_CFG_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        dis_ctrl[3] && (accel_en != 3'b000) |-> cfg_err); // R11
    AST_CFG_CLEAN: assert property (@(posedge clk) disable iff (rst)
        !dis_ctrl[3] |-> !cfg_err); // R11
endmodule

// File: tb/virt_trap_decider_test.sv
`timescale 1ns/1ps
module virt_trap_decider_test;
    localparam int MW = 24;
    localparam int IB = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_class = '0;
    logic [MW-1:0] acc_mask = '0;
    logic          guest_mode = 1'b0;
    logic [3:0]    dis_ctrl = '0;
    logic [2:0]    accel_en = '0;
    logic          trap_vld, trap_out, cfg_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    logic last_exp = 1'b0;

    always #10 clk = ~clk;

    virt_trap_decider #(.MASK_W(MW), .INT_BIT(IB)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_class(acc_class),
        .acc_mask(acc_mask), .guest_mode(guest_mode), .dis_ctrl(dis_ctrl),
        .accel_en(accel_en), .trap_vld(trap_vld), .trap_out(trap_out),
        .cfg_err(cfg_err)
    );

    function automatic logic ref_trap(int c, logic [MW-1:0] m, logic g, logic [3:0] d);
        logic [MW-1:0] ib = '0;
        ib[IB] = 1'b1;
        if (!g) return 1'b0;
        case (c)
            1, 2: return !d[0];
            3:    return !d[1];
            5:    return !d[2];
            6: begin
                if (m == '0) return 1'b0;
                if (m == ib && d[3]) return 1'b0;
                return 1'b1;
            end
            7:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(int c, logic [MW-1:0] m, logic g);
        logic [MW-1:0] ib = '0;
        ib[IB] = 1'b1;
        if (!g) return "R2";
        case (c)
            0: return "R9";
            1, 2: return "R3";
            3, 4: return "R4";
            5: return "R5";
            6: return (m == ib) ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply(int c, logic [MW-1:0] m, logic g, logic [3:0] d, logic [2:0] a);
        logic e;
        @(negedge clk);
        acc_valid = 1'b1; acc_class = 3'(c); acc_mask = m;
        guest_mode = g; dis_ctrl = d; accel_en = a;
        #1;
        check("R11", cfg_err, d[3] & (a != 3'b000));
        e = ref_trap(c, m, g, d);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10", trap_vld, 1'b1);
        check(tag_of(c, m, g), trap_out, e);
        last_exp = e;
    endtask

    task automatic idle_hold();
        @(negedge clk);
        acc_valid = 1'b0;
        acc_class = 3'($urandom_range(7));
        acc_mask = MW'($urandom);
        guest_mode = 1'($urandom);
        dis_ctrl = 4'($urandom);
        @(negedge clk);
        check("R10", trap_vld, 1'b0);
        check("R10", trap_out, last_exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [MW-1:0] ibm;
        logic [MW-1:0] pair;
        void'($urandom(32'd2024));
        ibm = '0; ibm[IB] = 1'b1;
        pair = ibm; pair[IB+1] = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", trap_out, 1'b0);
        check("R1", trap_vld, 1'b0);
        rst = 1'b0;

        // R2: host mode, every class, all bypasses cleared
        for (int c = 0; c < 8; c++) apply(c, pair, 1'b0, 4'h0, 3'b000);
        // R3/R4/R5/R9: guest mode with bypass on and off
        for (int c = 0; c < 6; c++) begin
            apply(c, '0, 1'b1, 4'h0, 3'b000);
            apply(c, '0, 1'b1, 4'h7, 3'b000);
        end
        // R6: interrupt bit alone
        apply(6, ibm, 1'b1, 4'h8, 3'b000);
        apply(6, ibm, 1'b1, 4'h7, 3'b000);
        // R7: interrupt bit plus another, other bit alone, zero mask
        apply(6, pair, 1'b1, 4'hF, 3'b000);
        apply(6, MW'(1), 1'b1, 4'hF, 3'b000);
        apply(6, '0, 1'b1, 4'h0, 3'b000);
        // R8: whole-word move with every bypass
        apply(7, ibm, 1'b1, 4'hF, 3'b000);
        apply(7, '0, 1'b1, 4'hF, 3'b000);
        idle_hold();
        // R11: sweep accelerations against the interrupt-bit bypass
        for (int a = 0; a < 8; a++) begin
            apply(0, '0, 1'b1, 4'h8, 3'(a));
            apply(0, '0, 1'b1, 4'h7, 3'(a));
        end
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [MW-1:0] m;
            case ($urandom_range(3))
                0: m = ibm;
                1: m = pair;
                2: m = '0;
                default: m = MW'($urandom);
            endcase
            apply($urandom_range(7), m, 1'($urandom), 4'($urandom), 3'($urandom));
            if ($urandom_range(3) == 0) idle_hold();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule